// File: doc/BRIEF.md
# Windowed Watchdog Timer with Keyed Commands

The block is a watchdog timer behind a single-cycle register port. A 16-bit counter advances on pulses from one of four tick inputs, optionally divided by 256, and is compared against a 16-bit timeout. Software keeps the system alive by writing a refresh key to the counter register. If the count reaches the timeout, the block raises a reset request. When the interrupt is enabled, it first sets an early-warning flag and raises the reset request 128 bus cycles later.

The control, timeout and window registers are protected. An unlock key opens a configuration window of 128 bus cycles. Inside that window each protected register accepts exactly one write. Keys are written either as one 32-bit word or as two 16-bit halves, low half first, depending on a control bit.

In window mode, a refresh that arrives before the counter reaches the window value is treated as a fault. The wait, stop and debug inputs freeze the counter unless the matching run bit is set.

Top module: `wdt_windowed`

## Requirements
- R1: Register map by `addr_i`: 0 control, 1 counter, 2 timeout, 3 window. Control bits: 0 enable, 1 interrupt enable, 2 update allowed, 3 window mode, 4 32-bit commands, 6:5 tick source, 7 divide-by-256, 8 run-in-wait, 9 run-in-stop, 10 run-in-debug, 12:11 test mode, 13 interrupt flag, 14 configuration window open (read only). After reset, control reads 0x135, timeout reads 0xFFFF, window reads 0, and the counter reads 0, with `irq_o` and `rst_req_o` low.
- R2: While enabled, the counter increments once for each pulse on the tick input selected by control bits 6:5. Pulses on the other tick inputs are ignored.
- R3: With control bit 7 set, the counter advances once per 256 pulses of the selected tick.
- R4: The counter holds its value while `wait_i`, `stop_i` or `dbg_i` is high and the matching run bit is clear.
- R5: With control bit 4 set, a single write of 0xB480A602 to the counter register is a refresh, and a single write of 0xD928C520 is an unlock. Any other value written there is ignored.
- R6: With control bit 4 clear, a refresh is a write of 0xA602 followed by 0xB480, and an unlock is 0xC520 followed by 0xD928. If the write after a first half is anything other than the correct second half to the counter register, `rst_req_o` is asserted.
- R7: Writes to the control, timeout and window registers take effect only while the configuration window is open. The window is 128 cycles long, starts at an unlock, and allows one write per register.
- R8: An unlock is ignored while control bit 2 is clear.
- R9: A refresh clears the counter to 0, and it takes precedence over a tick in the same cycle. In window mode, a refresh while the counter is below the window value asserts `rst_req_o`.
- R10: With the interrupt disabled, `rst_req_o` rises two cycles after the counter reaches the timeout.
- R11: With the interrupt enabled, reaching the timeout sets the flag and raises `irq_o` one cycle later, and `rst_req_o` follows 128 cycles after `irq_o`. Writing 1 to control bit 13 clears the flag.
- R12: Test mode 2 compares only bits 7:0 of the counter and the timeout. Test mode 3 compares only bits 15:8.
- R13: Once asserted, `rst_req_o` stays high until `rst_ni` is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register select for reads and writes |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| tick_i | input | 4 | Candidate counter tick pulses |
| wait_i | input | 1 | Wait mode active |
| stop_i | input | 1 | Stop mode active |
| dbg_i | input | 1 | Debug mode active |
| irq_o | output | 1 | Early-warning interrupt |
| rst_req_o | output | 1 | Reset request to the system |

## Verification
A refresh and a counter tick can land in the same cycle. The bench provokes this by raising the selected tick input during the write that completes a refresh, and it expects the counter to read 0 afterwards rather than 1. A window-mode refresh can also coincide with a count that sits just below or at the window value. Both sides of that boundary are driven, and the outcome is judged on `rst_req_o`.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic [31:0] REF_KEY = 32'hB480_A602;
  localparam logic [31:0] UNL_KEY = 32'hD928_C520;
  localparam int N_SRC = 4;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_CNT  = 2'd1;
  localparam logic [1:0] A_TOV  = 2'd2;
  localparam logic [1:0] A_WIN  = 2'd3;

  typedef struct packed {
    logic [1:0] tmode;
    logic       run_dbg;
    logic       run_stop;
    logic       run_wait;
    logic       pres;
    logic [1:0] clk_src;
    logic       cmd32;
    logic       win_en;
    logic       upd;
    logic       int_en;
    logic       en;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
  localparam logic [CTRL_W-1:0] CTRL_RST = 13'h135;

  typedef enum logic [1:0] {KS_IDLE, KS_REF, KS_UNL} ks_e;
endpackage

// File: rtl/wdt_keyseq.sv
module wdt_keyseq
  import wdt_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_any_i,
  input  logic        wr_cmd_i,
  input  logic [31:0] wdata_i,
  input  logic        cmd32_i,
  output logic        refresh_o,
  output logic        unlock_o,
  output logic        seq_err_o
);
  ks_e st_q, st_d;

  always_comb begin
    st_d      = st_q;
    refresh_o = 1'b0;
    unlock_o  = 1'b0;
    seq_err_o = 1'b0;
    if (wr_any_i) begin
      if (st_q != KS_IDLE) begin
        st_d = KS_IDLE;
        if (wr_cmd_i && st_q == KS_REF && wdata_i[15:0] == REF_KEY[31:16])
          refresh_o = 1'b1;
        else if (wr_cmd_i && st_q == KS_UNL && wdata_i[15:0] == UNL_KEY[31:16])
          unlock_o = 1'b1;
        else
          seq_err_o = 1'b1;  // broken two-write sequence
      end else if (wr_cmd_i) begin
        if (cmd32_i) begin
          refresh_o = (wdata_i == REF_KEY);
          unlock_o  = (wdata_i == UNL_KEY);
        end else if (wdata_i[15:0] == REF_KEY[15:0]) begin
          st_d = KS_REF;
        end else if (wdata_i[15:0] == UNL_KEY[15:0]) begin
          st_d = KS_UNL;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) st_q <= KS_IDLE;
    else         st_q <= st_d;
endmodule

// File: rtl/wdt_ticker.sv
module wdt_ticker #(
  parameter int N_SRC = 4,
  parameter int PRE_W = 8,
  localparam int SEL_W = $clog2(N_SRC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] tick_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             pres_i,
  input  logic             run_i,
  output logic             tick_o
);
  logic [PRE_W-1:0] pc_q;
  logic src;

  assign src    = tick_i[sel_i] & run_i;
  assign tick_o = src & (~pres_i | (&pc_q));

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)             pc_q <= '0;
    else if (src && pres_i)  pc_q <= pc_q + 1'b1;
endmodule

// File: rtl/wdt_windowed.sv
module wdt_windowed
  import wdt_pkg::*;
#(
  parameter int CFG_WIN  = 128,
  parameter int IRQ_LEAD = 128,
  parameter int PRE_W    = 8,
  localparam int CFG_CW  = $clog2(CFG_WIN + 1),
  localparam int LEAD_W  = $clog2(IRQ_LEAD + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       addr_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o,
  input  logic [N_SRC-1:0] tick_i,
  input  logic             wait_i,
  input  logic             stop_i,
  input  logic             dbg_i,
  output logic             irq_o,
  output logic             rst_req_o
);
  ctrl_t             ctrl;
  logic              flg, tmo, rst_q;
  logic [15:0]       cnt, toval, win;
  logic [CFG_CW-1:0] cfg_cnt;
  logic              wo_ctrl, wo_tov, wo_win;
  logic [LEAD_W-1:0] dly;

  logic cfg_open, wr_cmd, refresh, unlock, seq_err, unlock_ok;
  logic lp_hold, run, tick, match, win_bad, hit;

  assign cfg_open = (cfg_cnt != '0);
  assign wr_cmd   = wr_en_i && addr_i == A_CNT;

  wdt_keyseq u_keys (
    .clk_i, .rst_ni,
    .wr_any_i (wr_en_i),
    .wr_cmd_i (wr_cmd),
    .wdata_i,
    .cmd32_i  (ctrl.cmd32),
    .refresh_o(refresh),
    .unlock_o (unlock),
    .seq_err_o(seq_err)
  );

  assign unlock_ok = unlock && ctrl.upd;
  assign lp_hold   = (wait_i && !ctrl.run_wait) || (stop_i && !ctrl.run_stop) ||
                     (dbg_i && !ctrl.run_dbg);
  assign run       = ctrl.en && !lp_hold && !tmo;

  wdt_ticker #(.N_SRC(N_SRC), .PRE_W(PRE_W)) u_tick (
    .clk_i, .rst_ni,
    .tick_i,
    .sel_i (ctrl.clk_src),
    .pres_i(ctrl.pres),
    .run_i (run),
    .tick_o(tick)
  );

  always_comb
    case (ctrl.tmode)
      2'd2:    match = (cnt[7:0]  == toval[7:0]);
      2'd3:    match = (cnt[15:8] == toval[15:8]);
      default: match = (cnt == toval);
    endcase

  assign win_bad = refresh && ctrl.win_en && (cnt < win);
  assign hit     = ctrl.en && match && !tmo;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      ctrl    <= ctrl_t'(CTRL_RST);
      toval   <= 16'hFFFF;
      win     <= '0;
      cfg_cnt <= '0;
      wo_ctrl <= 1'b0;
      wo_tov  <= 1'b0;
      wo_win  <= 1'b0;
    end else begin
      if (unlock_ok) begin
        cfg_cnt <= CFG_CW'(CFG_WIN);
        wo_ctrl <= 1'b0;
        wo_tov  <= 1'b0;
        wo_win  <= 1'b0;
      end else if (cfg_open) begin
        cfg_cnt <= cfg_cnt - 1'b1;
      end
      if (wr_en_i && cfg_open) begin
        if (addr_i == A_CTRL && !wo_ctrl) begin
          ctrl    <= ctrl_t'(wdata_i[CTRL_W-1:0]);
          wo_ctrl <= 1'b1;
        end
        if (addr_i == A_TOV && !wo_tov) begin
          toval  <= wdata_i[15:0];
          wo_tov <= 1'b1;
        end
        if (addr_i == A_WIN && !wo_win) begin
          win    <= wdata_i[15:0];
          wo_win <= 1'b1;
        end
      end
    end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      cnt   <= '0;
      tmo   <= 1'b0;
      flg   <= 1'b0;
      dly   <= '0;
      rst_q <= 1'b0;
    end else begin
      if (refresh && !win_bad) cnt <= '0;
      else if (tick)           cnt <= cnt + 1'b1;
      if (hit) tmo <= 1'b1;
      if (hit && ctrl.int_en) flg <= 1'b1;
      else if (wr_en_i && addr_i == A_CTRL && wdata_i[13]) flg <= 1'b0;
      if (seq_err || win_bad) rst_q <= 1'b1;
      if (tmo) begin
        if (!ctrl.int_en || dly == LEAD_W'(IRQ_LEAD - 1)) rst_q <= 1'b1;
        else dly <= dly + 1'b1;
      end
    end

  assign irq_o     = flg && ctrl.int_en;
  assign rst_req_o = rst_q;

  always_comb
    case (addr_i)
      A_CTRL:  rdata_o = {17'b0, cfg_open, flg, ctrl};
      A_CNT:   rdata_o = {16'b0, cnt};
      A_TOV:   rdata_o = {16'b0, toval};
      default: rdata_o = {16'b0, win};
    endcase
endmodule

// File: rtl/wdt_chk.sv
module wdt_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        rst_req_i,
  input logic        irq_i,
  input logic        int_en_i,
  input logic        refresh_i,
  input logic        win_bad_i,
  input logic [15:0] cnt_i,
  input logic        wait_i,
  input logic        stop_i,
  input logic        dbg_i,
  input logic        run_wait_i,
  input logic        run_stop_i,
  input logic        run_dbg_i,
  input logic        cfg_open_i,
  input logic [15:0] toval_i
);
  logic gated;
  assign gated = (wait_i & ~run_wait_i) | (stop_i & ~run_stop_i) | (dbg_i & ~run_dbg_i);

  p_rst_sticky_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_i |=> rst_req_i);

  p_irq_needs_en_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> int_en_i);

  p_refresh_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (refresh_i && !win_bad_i) |=> cnt_i == 16'd0);

  p_win_fault_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_bad_i |=> rst_req_i);

  p_gate_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gated && !refresh_i) |=> $stable(cnt_i));

  p_toval_locked_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_open_i |=> $stable(toval_i));
endmodule

bind wdt_windowed wdt_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rst_req_i  (rst_req_o),
  .irq_i      (irq_o),
  .int_en_i   (ctrl.int_en),
  .refresh_i  (refresh),
  .win_bad_i  (win_bad),
  .cnt_i      (cnt),
  .wait_i     (wait_i),
  .stop_i     (stop_i),
  .dbg_i      (dbg_i),
  .run_wait_i (ctrl.run_wait),
  .run_stop_i (ctrl.run_stop),
  .run_dbg_i  (ctrl.run_dbg),
  .cfg_open_i (cfg_open),
  .toval_i    (toval)
);

// File: tb/sim_wdt_windowed.sv
module sim_wdt_windowed;
  localparam int CLK_PER = 10;
  localparam int LEAD = 128;
  localparam int WIN = 128;

  logic clk = 0, rst_ni = 0, we = 0, wait_m = 0, stop_m = 0, dbg_m = 0;
  logic [1:0] addr = 0;
  logic [31:0] wd = 0;
  logic [3:0] tk = 0;
  logic [31:0] rdata;
  logic irq, rreq;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  int qk[$];
  logic [31:0] qe[$];
  string qt[$];

  always #(CLK_PER/2) clk = ~clk;

  wdt_windowed u0 (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(we), .addr_i(addr), .wdata_i(wd),
    .rdata_o(rdata), .tick_i(tk), .wait_i(wait_m), .stop_i(stop_m), .dbg_i(dbg_m),
    .irq_o(irq), .rst_req_o(rreq)
  );

  // monitor: pops expected items and compares
  always @(negedge clk) begin
    if (qk.size() > 0) begin
      automatic int k = qk.pop_front();
      automatic logic [31:0] e = qe.pop_front();
      automatic string t = qt.pop_front();
      automatic logic [31:0] a = (k == 0) ? rdata : (k == 1) ? {31'b0, irq} : {31'b0, rreq};
      n_chk++;
      if (a !== e) begin
        n_fail++;
        $display("FAIL %s actual=%h expected=%h", t, a, e);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic chk(input int k, input logic [1:0] a, input logic [31:0] e, input string t);
    @(posedge clk); #1;
    if (k == 0) addr = a;
    qk.push_back(k); qe.push_back(e); qt.push_back(t);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic with_tick = 0);
    @(posedge clk); #1;
    we = 1; addr = a; wd = d;
    if (with_tick) tk[1] = 1;
    @(posedge clk); #1;
    we = 0; tk = 0;
  endtask

  task automatic pulse(input int n, input int src);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1 tk[src] = 1;
      @(posedge clk); #1 tk[src] = 0;
    end
  endtask

  task automatic do_reset;
    @(posedge clk); #1;
    rst_ni = 0; we = 0; tk = 0; wait_m = 0; stop_m = 0; dbg_m = 0;
    idle(2); #1 rst_ni = 1;
  endtask

  task automatic unlock32; wr(2'd1, 32'hD928C520); endtask
  task automatic refresh32; wr(2'd1, 32'hB480A602); endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    chk(0, 2'd0, 32'h135, "R1 ctrl");
    chk(0, 2'd2, 32'hFFFF, "R1 timeout");
    chk(0, 2'd3, 32'h0, "R1 window");
    chk(0, 2'd1, 32'h0, "R1 counter");
    chk(1, 0, 0, "R1 irq");
    chk(2, 0, 0, "R1 rst_req");

    // R2 source select
    pulse(5, 1);
    chk(0, 2'd1, 5, "R2 src1 count");
    pulse(3, 0);
    chk(0, 2'd1, 5, "R2 other src ignored");
    // R7 write-once requires unlock
    wr(2'd2, 32'd10);
    chk(0, 2'd2, 32'hFFFF, "R7 locked timeout");
    unlock32();
    chk(0, 2'd0, 32'h4135, "R7 window open bit");
    wr(2'd2, 32'h20);
    wr(2'd2, 32'h30);
    chk(0, 2'd2, 32'h20, "R7 single write");
    wr(2'd0, 32'h115);
    pulse(2, 0);
    chk(0, 2'd1, 7, "R2 src0 after select");
    // R5 32-bit keys
    wr(2'd1, 32'h12345678);
    chk(0, 2'd1, 7, "R5 bad key ignored");
    chk(2, 0, 0, "R5 no reset on bad key");
    refresh32();
    chk(0, 2'd1, 0, "R5 refresh32");
    idle(WIN + 2);
    wr(2'd3, 32'd9);
    chk(0, 2'd3, 0, "R7 window expired");
    chk(0, 2'd0, 32'h115, "R7 window closed bit");

    // R3 prescaler
    do_reset();
    unlock32(); wr(2'd0, 32'h1B5);
    pulse(255, 1);
    chk(0, 2'd1, 0, "R3 255 ticks");
    pulse(1, 1);
    chk(0, 2'd1, 1, "R3 256 ticks");

    // R4 low-power gating
    do_reset();
    stop_m = 1; pulse(3, 1);
    chk(0, 2'd1, 0, "R4 stop holds");
    stop_m = 0; dbg_m = 1; pulse(2, 1);
    chk(0, 2'd1, 0, "R4 debug holds");
    dbg_m = 0; wait_m = 1; pulse(2, 1);
    chk(0, 2'd1, 2, "R4 wait runs");
    wait_m = 0;

    // R6 16-bit keys
    unlock32(); wr(2'd0, 32'h125);
    pulse(3, 1);
    wr(2'd1, 32'hA602);
    chk(0, 2'd1, 5, "R6 half refresh no effect");
    wr(2'd1, 32'hB480);
    chk(0, 2'd1, 0, "R6 refresh16");
    idle(WIN + 2);
    wr(2'd1, 32'hC520); wr(2'd1, 32'hD928);
    wr(2'd3, 32'd7);
    chk(0, 2'd3, 7, "R6 unlock16");
    wr(2'd1, 32'hA602); wr(2'd2, 32'h55);
    chk(2, 0, 1, "R6 interrupted sequence");
    idle(10); wr(2'd0, 32'h2000);
    chk(2, 0, 1, "R13 sticky request");
    do_reset();
    unlock32(); wr(2'd0, 32'h125);
    wr(2'd1, 32'hC520); wr(2'd1, 32'h1234);
    chk(2, 0, 1, "R6 wrong second half");

    // R8 unlock needs update bit
    do_reset();
    unlock32(); wr(2'd0, 32'h131);
    idle(WIN + 2);
    unlock32();
    chk(0, 2'd0, 32'h131, "R8 unlock ignored");
    wr(2'd2, 32'h44);
    chk(0, 2'd2, 32'hFFFF, "R8 timeout locked");

    // R9 window refresh
    do_reset();
    unlock32(); wr(2'd3, 32'd4); wr(2'd0, 32'h13D);
    pulse(3, 1);
    refresh32();
    chk(2, 0, 1, "R9 early refresh");
    do_reset();
    unlock32(); wr(2'd3, 32'd4); wr(2'd0, 32'h13D);
    pulse(4, 1);
    wr(2'd1, 32'hB480A602, 1);
    chk(0, 2'd1, 0, "R9 refresh beats tick");
    chk(2, 0, 0, "R9 refresh at window ok");

    // R10 timeout without interrupt
    do_reset();
    unlock32(); wr(2'd2, 32'd3);
    pulse(3, 1);
    chk(2, 0, 0, "R10 one cycle after match");
    chk(2, 0, 1, "R10 reset request");
    chk(1, 0, 0, "R10 no irq");

    // R11 interrupt lead
    do_reset();
    unlock32(); wr(2'd2, 32'd2); wr(2'd0, 32'h137);
    pulse(2, 1);
    chk(1, 0, 1, "R11 irq raised");
    chk(2, 0, 0, "R11 request waits");
    idle(LEAD - 3);
    chk(2, 0, 0, "R11 request one before lead");
    chk(2, 0, 1, "R11 request at lead");
    wr(2'd0, 32'h2000);
    chk(1, 0, 0, "R11 flag cleared");

    // R12 byte test mode
    do_reset();
    unlock32(); wr(2'd2, 32'hFF03); wr(2'd0, 32'h1135);
    pulse(3, 1);
    chk(2, 0, 0, "R12 one cycle after");
    chk(2, 0, 1, "R12 low byte match");
    do_reset();
    unlock32(); wr(2'd2, 32'hFF03);
    pulse(3, 1);
    idle(3);
    chk(2, 0, 0, "R12 full compare no match");

    idle(2);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule